// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Writer

This block stores received Ethernet frames in memory. Software keeps a ring of two-word descriptors. The first word of each descriptor is a buffer address. Its low two bits are flags: bit 0 marks the descriptor as owned by software, and bit 1 marks the last entry of the ring. The second word is a status word that the block fills in. The block takes a byte stream that carries start-of-frame and end-of-frame markers. It writes each byte into the current buffer. When a buffer is full or the frame ends, it writes the status word and then hands the descriptor back by setting the ownership bit.

After the ring base register is written, the block reads the descriptor at the ring pointer ahead of time. A frame is accepted only if that descriptor is free. A frame larger than one buffer continues in the next descriptor. A three-bit status register reports overflow, frame received and no buffer available. Each of these bits is cleared by writing a 1 to it. An interrupt output follows the frame-received bit when the interrupt is enabled.

Top module: `rxring_rx_dma`

## Requirements
- R1: After reset, all status bits and `irq` are 0, and the first memory access is a descriptor read with `memWe` low.
- R2: The buffer address is the descriptor address word with bits 1:0 forced to zero. The byte at position k of a buffer goes to buffer address + k. The byte is placed on all four data lanes, and the single strobe `memBe` bit equals address bits 1:0.
- R3: After a buffer is used, the block sets bit 0 of its address word and keeps all other bits. The block never writes data into a descriptor whose bit 0 is set.
- R4: Descriptors are 8 bytes apart. After a descriptor whose address word has bit 1 set, the next descriptor is the one at the ring base.
- R5: The status word sits at descriptor + 4. Bits 11:0 hold the length, bit 14 marks the first buffer of a frame and bit 15 marks the last buffer. Every buffer except the last reports length 0, and the last buffer reports the whole frame length.
- R6: `statusBits` bit 0 is overflow, bit 1 is frame received and bit 2 is no buffer available. Writing a 1 to a bit of `statClr` clears that bit only.
- R7: `irq` is high exactly when frame received is set and `irqEn` is high.
- R8: If the descriptor at the pointer is owned when a frame starts, the whole frame is dropped with no memory write, no buffer available is set, and the pointer does not move.
- R9: If the next descriptor is owned when a frame needs another buffer, no buffer available is set, the rest of the frame is dropped, and frame received is not set.
- R10: A byte that arrives while the one-byte holding register is full and is not being emptied in that cycle is lost, and the overflow bit is set.
- R11: Bytes that arrive outside a frame are ignored.
- R12: A memory request keeps its address, write enable and write data stable until `memAck` is seen.
- R13: Writing the ring base register reloads the ring pointer. The base is rounded down to a multiple of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Byte valid on the receive stream |
| inByte | input | 8 | Received byte |
| inSof | input | 1 | This byte starts a frame |
| inEof | input | 1 | This byte ends a frame |
| baseWe | input | 1 | Write strobe for the ring base register |
| baseData | input | AW | New ring base address |
| statClr | input | 3 | Write-one-to-clear mask for the status bits |
| irqEn | input | 1 | Frame-received interrupt enable |
| statusBits | output | 3 | {no buffer, frame received, overflow} |
| irq | output | 1 | Frame-received interrupt |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memBe | output | 4 | Byte strobes |
| memAddr | output | AW | Byte address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid while memAck is high |
| memAck | input | 1 | Request completed |

## Verification
Random frame lengths from 1 to 260 bytes are sent against a memory model that adds random wait states. These frames tell single-buffer frames apart from frames that cross buffer boundaries and wrap around the ring. Fixed lengths of 128 and 129 bytes test the cases where the end of frame lands exactly on a buffer edge or one byte past it. Three other cases are driven on purpose, each producing a different status pattern: a full ring of owned descriptors, an owned descriptor reached in the middle of a frame, and a back-to-back byte burst. Stray bytes outside any frame and a period with the interrupt disabled show that these inputs cause no memory write and raise no interrupt.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int unsigned SOF_BIT = 14;
  localparam int unsigned EOF_BIT = 15;
  localparam int unsigned DESC_BYTES = 8;

  typedef enum logic [2:0] {
    OP_NONE, OP_RDDESC, OP_WRDATA, OP_WRSTAT, OP_WROWN
  } memOp_e;

  typedef struct packed {
    memOp_e op;
    logic   holdPop;
    logic   dropStart;
    logic   offClr;
    logic   lenClr;
    logic   ptrAdv;
    logic   descLoad;
    logic   setBna;
    logic   setFrm;
    logic   statFirst;
    logic   statLast;
  } ctlStrobe_t;
endpackage

// File: rtl/rxring_datapath.sv
module rxring_datapath
  import rxring_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned BUF_BYTES = 128,
  parameter int unsigned LEN_W = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    ctl,
  input  logic          inValid,
  input  logic [7:0]    inByte,
  input  logic          inSof,
  input  logic          inEof,
  input  logic          baseWe,
  input  logic [AW-1:0] baseData,
  input  logic [2:0]    statClr,
  input  logic          memAck,
  input  logic [31:0]   memRdata,
  output logic          memReq,
  output logic          memWe,
  output logic [3:0]    memBe,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  output logic          holdFull,
  output logic          holdSof,
  output logic          holdEof,
  output logic          descOwned,
  output logic          bufLast,
  output logic [2:0]    statusBits
);
  localparam int unsigned OFF_W = $clog2(BUF_BYTES);

  logic [7:0]       holdByte;
  logic             dropping, dropAct, takeByte, ovfEvt, wrDone;
  logic [OFF_W-1:0] offset;
  logic [LEN_W-1:0] frameLen, lenField;
  logic [AW-1:0]    ringBase, ringPtr, descWord, bufBase, dataAddr;
  logic [31:0]      statWord;

  assign dropAct  = dropping | ctl.dropStart;
  assign takeByte = inValid && !dropAct && (!holdFull || ctl.holdPop);
  assign ovfEvt   = inValid && !dropAct && holdFull && !ctl.holdPop;
  assign wrDone   = (ctl.op == OP_WRDATA) && memAck;

  assign descOwned = descWord[0];
  assign bufLast   = (offset == OFF_W'(BUF_BYTES - 1));
  assign bufBase   = descWord & ~AW'(3);
  assign dataAddr  = bufBase + AW'(offset);
  assign lenField  = ctl.statLast ? frameLen : '0;
  assign statWord  = 32'(lenField) | (32'(ctl.statFirst) << SOF_BIT)
                   | (32'(ctl.statLast) << EOF_BIT);

  // hold register and frame drop tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      holdByte <= '0;
      holdSof  <= 1'b0;
      holdEof  <= 1'b0;
      dropping <= 1'b0;
    end else begin
      if (takeByte) begin
        holdFull <= 1'b1;
        holdByte <= inByte;
        holdSof  <= inSof;
        holdEof  <= inEof;
      end else if (ctl.holdPop) begin
        holdFull <= 1'b0;
      end
      if (ctl.dropStart)
        dropping <= !(holdFull && holdEof) && !(inValid && inEof);
      else if (dropping && inValid && inEof)
        dropping <= 1'b0;
    end
  end

  // pointers, counters, descriptor copy, status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ringBase   <= '0;
      ringPtr    <= '0;
      descWord   <= '0;
      offset     <= '0;
      frameLen   <= '0;
      statusBits <= '0;
    end else begin
      if (baseWe) begin
        ringBase <= baseData & ~AW'(7);
        ringPtr  <= baseData & ~AW'(7);
      end else if (ctl.ptrAdv) begin
        ringPtr <= descWord[1] ? ringBase : ringPtr + AW'(DESC_BYTES);
      end
      if (ctl.descLoad) descWord <= memRdata[AW-1:0];
      if (ctl.offClr) offset <= '0;
      else if (wrDone) offset <= offset + 1'b1;
      if (ctl.lenClr) frameLen <= '0;
      else if (wrDone) frameLen <= frameLen + 1'b1;
      statusBits <= (statusBits & ~statClr) | {ctl.setBna, ctl.setFrm, ovfEvt};
    end
  end

  always_comb begin
    memReq   = (ctl.op != OP_NONE);
    memWe    = memReq && (ctl.op != OP_RDDESC);
    memBe    = 4'hF;
    memAddr  = ringPtr;
    memWdata = '0;
    unique case (ctl.op)
      OP_WRDATA: begin
        memAddr  = dataAddr;
        memBe    = 4'b0001 << dataAddr[1:0];
        memWdata = {4{holdByte}};
      end
      OP_WRSTAT: begin
        memAddr  = ringPtr + AW'(4);
        memWdata = statWord;
      end
      OP_WROWN: memWdata = 32'(descWord | AW'(1));
      default: ;
    endcase
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck && !baseWe |=> memReq && $stable(memAddr)
      && $stable(memWdata) && $stable(memWe));

  // R4
  desc_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && (ctl.op != OP_WRDATA) |-> memAddr[1:0] == 2'b00);

  // R10
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusBits[0]) |-> $past(inValid && holdFull));
endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       baseWe,
  input  logic       memAck,
  input  logic       rdOwned,
  input  logic       holdFull,
  input  logic       holdSof,
  input  logic       holdEof,
  input  logic       descOwned,
  input  logic       bufLast,
  output ctlStrobe_t ctl
);
  typedef enum logic [2:0] {S_FETCH, S_IDLE, S_DATA, S_STAT, S_OWN} state_e;

  state_e state, nextState;
  logic   midFrame, nMid, lastSeg, nLast, firstSeg, nFirst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_FETCH;
      midFrame <= 1'b0;
      lastSeg  <= 1'b0;
      firstSeg <= 1'b0;
    end else begin
      state    <= nextState;
      midFrame <= nMid;
      lastSeg  <= nLast;
      firstSeg <= nFirst;
    end
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    nMid      = midFrame;
    nLast     = lastSeg;
    nFirst    = firstSeg;
    unique case (state)
      S_FETCH: begin
        ctl.op = OP_RDDESC;
        if (memAck) begin
          ctl.descLoad = 1'b1;
          if (midFrame) begin
            nMid = 1'b0;
            if (!rdOwned) begin
              nextState  = S_DATA;
              ctl.offClr = 1'b1;
            end else begin
              ctl.setBna    = 1'b1;
              ctl.dropStart = 1'b1;
              ctl.holdPop   = holdFull;
            end
          end else begin
            nextState = S_IDLE;
          end
        end
      end
      S_IDLE: begin
        if (holdFull) begin
          if (!holdSof) begin
            ctl.holdPop = 1'b1;
          end else if (descOwned) begin
            ctl.setBna    = 1'b1;
            ctl.dropStart = 1'b1;
            ctl.holdPop   = 1'b1;
          end else begin
            nextState  = S_DATA;
            ctl.offClr = 1'b1;
            ctl.lenClr = 1'b1;
            nFirst     = 1'b1;
          end
        end else if (descOwned) begin
          nextState = S_FETCH;
        end
      end
      S_DATA: begin
        if (holdFull) begin
          ctl.op = OP_WRDATA;
          if (memAck) begin
            ctl.holdPop = 1'b1;
            if (holdEof) begin
              nLast     = 1'b1;
              nextState = S_STAT;
            end else if (bufLast) begin
              nLast     = 1'b0;
              nextState = S_STAT;
            end
          end
        end
      end
      S_STAT: begin
        ctl.op        = OP_WRSTAT;
        ctl.statFirst = firstSeg;
        ctl.statLast  = lastSeg;
        if (memAck) nextState = S_OWN;
      end
      S_OWN: begin
        ctl.op = OP_WROWN;
        if (memAck) begin
          ctl.ptrAdv = 1'b1;
          ctl.setFrm = lastSeg;
          nFirst     = 1'b0;
          nMid       = !lastSeg;
          nextState  = S_FETCH;
        end
      end
      default: nextState = S_FETCH;
    endcase
    if (baseWe) begin
      nextState = S_FETCH;
      nMid      = 1'b0;
    end
  end

  // R3
  no_owned_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == S_DATA |-> !descOwned);

  // R2
  data_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == S_DATA && ctl.op == OP_WRDATA |-> holdFull);
endmodule

// File: rtl/rxring_rx_dma.sv
module rxring_rx_dma
  import rxring_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned BUF_BYTES = 128,
  parameter int unsigned LEN_W = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [7:0]    inByte,
  input  logic          inSof,
  input  logic          inEof,
  input  logic          baseWe,
  input  logic [AW-1:0] baseData,
  input  logic [2:0]    statClr,
  input  logic          irqEn,
  output logic [2:0]    statusBits,
  output logic          irq,
  output logic          memReq,
  output logic          memWe,
  output logic [3:0]    memBe,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  input  logic          memAck
);
  ctlStrobe_t ctl;
  logic holdFull, holdSof, holdEof, descOwned, bufLast;

  rxring_ctrl i_ctrl (
    .clk, .rstN, .baseWe, .memAck,
    .rdOwned(memRdata[0]),
    .holdFull, .holdSof, .holdEof, .descOwned, .bufLast,
    .ctl
  );

  rxring_datapath #(.AW(AW), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) i_dp (
    .clk, .rstN, .ctl, .inValid, .inByte, .inSof, .inEof,
    .baseWe, .baseData, .statClr, .memAck, .memRdata,
    .memReq, .memWe, .memBe, .memAddr, .memWdata,
    .holdFull, .holdSof, .holdEof, .descOwned, .bufLast, .statusBits
  );

  assign irq = statusBits[1] & irqEn;

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> statusBits[1] && irqEn);
endmodule

// File: tb/test_rxring_rx_dma.sv
module test_rxring_rx_dma;
  localparam int AW = 32;
  localparam int BUFB = 128;
  localparam int NDESC = 4;
  localparam logic [31:0] BASE = 32'h100;
  localparam logic [31:0] BUFAREA = 32'h400;

  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 0, inSof = 0, inEof = 0, baseWe = 0, irqEn = 1;
  logic [7:0] inByte = 0;
  logic [AW-1:0] baseData = 0;
  logic [2:0] statClr = 0, statusBits;
  logic irq, memReq, memWe, memAck = 0;
  logic [3:0] memBe;
  logic [AW-1:0] memAddr;
  logic [31:0] memWdata, memRdata = 0;

  rxring_rx_dma i_rxring_rx_dma (.*);

  always #10 clk = ~clk;

  logic [31:0] mem [0:1023];
  logic swWe = 0;
  logic [31:0] swAddr = 0, swData = 0;
  int waitCnt = 0, memWrites = 0, r12Checks = 0, r12Fails = 0;
  logic pendPrev = 0, baseWePrev = 0, pWe = 0;
  logic [31:0] pAddr = 0, pData = 0;

  always @(negedge clk) begin
    memAck = 1'b0;
    if (swWe) mem[swAddr[11:2]] = swData;
    if (rstN && memReq) begin
      if (pendPrev && !baseWePrev) begin
        r12Checks++;
        if (memAddr != pAddr || memWe != pWe || memWdata != pData) begin
          r12Fails++;
          $display("FAIL R12 request changed before ack: actual %0h expected %0h", memAddr, pAddr);
        end
      end
      if (waitCnt == 0) begin
        if (memWe) begin
          for (int b = 0; b < 4; b++)
            if (memBe[b]) mem[memAddr[11:2]][8*b +: 8] = memWdata[8*b +: 8];
          memWrites++;
        end else begin
          memRdata = mem[memAddr[11:2]];
        end
        memAck = 1'b1;
        waitCnt = $urandom % 3;
        pendPrev = 1'b0;
      end else begin
        waitCnt--;
        pendPrev = 1'b1;
        pAddr = memAddr; pWe = memWe; pData = memWdata;
      end
    end else begin
      pendPrev = 1'b0;
    end
    baseWePrev = baseWe;
  end

  int checks = 0, fails = 0, swIdx = 0;
  bit timedOut = 0;
  logic [7:0] fb [0:511];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rdWord(logic [31:0] a);
    return mem[a[11:2]];
  endfunction

  function automatic logic [7:0] rdByte(logic [31:0] a);
    logic [31:0] w = mem[a[11:2]];
    return w[8*a[1:0] +: 8];
  endfunction

  task automatic swWrite(logic [31:0] a, logic [31:0] d);
    @(posedge clk);
    swAddr = a; swData = d; swWe = 1'b1;
    @(posedge clk);
    swWe = 1'b0;
  endtask

  task automatic clrStat(logic [2:0] m);
    @(negedge clk); statClr = m;
    @(negedge clk); statClr = 3'b000;
  endtask

  task automatic fillFrame(int len);
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
  endtask

  task automatic sendFrame(int len, int gap);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1; inByte = fb[i]; inSof = (i == 0); inEof = (i == len - 1);
      @(negedge clk);
      inValid = 0; inSof = 0; inEof = 0;
      repeat (gap) @(negedge clk);
    end
    repeat (40) @(negedge clk);
  endtask

  function automatic logic [31:0] descAt(int k);
    return BASE + 32'(8 * ((swIdx + k) % NDESC));
  endfunction

  task automatic checkFrame(int len);
    int nseg = (len + BUFB - 1) / BUFB;
    for (int k = 0; k < nseg; k++) begin
      logic [31:0] da = descAt(k);
      logic [31:0] aw = rdWord(da);
      logic [31:0] sw = rdWord(da + 4);
      bit last = (k == nseg - 1);
      int n = last ? len - k * BUFB : BUFB;
      int bad = 0;
      chk(aw[0] == 1'b1, "R3", "ownership bit", aw[0], 1);
      chk(aw[1] == (((swIdx + k) % NDESC) == NDESC - 1), "R4", "wrap bit kept", aw[1], 0);
      chk(sw[11:0] == (last ? 12'(len) : 12'd0), "R5", "length field", sw[11:0], last ? len : 0);
      chk(sw[15:14] == {last, k == 0}, "R5", "sof/eof flags", sw[15:14], {last, k == 0});
      for (int j = 0; j < n; j++)
        if (rdByte({aw[31:2], 2'b00} + 32'(j)) != fb[k * BUFB + j]) bad++;
      chk(bad == 0, "R2 R4", "buffer data mismatches", bad, 0);
    end
  endtask

  task automatic freeDescs(int cnt);
    for (int k = 0; k < cnt; k++) begin
      logic [31:0] da = descAt(k);
      swWrite(da, rdWord(da) & ~32'h1);
    end
  endtask

  task automatic normalFrame(int len, int gap);
    int nseg = (len + BUFB - 1) / BUFB;
    fillFrame(len);
    sendFrame(len, gap);
    checkFrame(len);
    chk(statusBits[1] == 1'b1, "R6", "frame received bit", statusBits[1], 1);
    chk(irq == irqEn, "R7", "irq level", irq, irqEn);
    clrStat(3'b010);
    chk(irq == 1'b0 && statusBits == 3'b000, "R6", "cleared by write one", statusBits, 0);
    freeDescs(nseg);
    swIdx = (swIdx + nseg) % NDESC;
  endtask

  task automatic runTests();
    int w0, len;
    for (int i = 0; i < NDESC; i++) begin
      swWrite(BASE + 32'(8 * i), (BUFAREA + 32'(i * BUFB)) | ((i == NDESC - 1) ? 32'h2 : 32'h0));
      swWrite(BASE + 32'(8 * i) + 4, 32'h0);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(statusBits == 3'b000 && irq == 1'b0, "R1", "status after reset", statusBits, 0);
    chk(memWe == 1'b0, "R1", "first access is a read", memWe, 0);
    baseData = BASE | 32'h5; baseWe = 1'b1;
    @(negedge clk); baseWe = 1'b0;
    repeat (10) @(negedge clk);

    // R11 stray bytes outside a frame
    w0 = memWrites;
    for (int i = 0; i < 5; i++) fb[i] = 8'(i + 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); inValid = 1; inByte = fb[i]; inEof = (i == 4);
      @(negedge clk); inValid = 0; inEof = 0;
      repeat (5) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    chk(memWrites == w0, "R11", "memory writes from stray bytes", memWrites - w0, 0);
    chk(statusBits == 3'b000, "R11", "status after stray bytes", statusBits, 0);

    // directed buffer edges; R13 base reload
    normalFrame(BUFB, 9);
    chk(rdWord(0) == 32'h0, "R13", "word at old pointer untouched", rdWord(0), 0);
    normalFrame(BUFB + 1, 9);

    for (int it = 0; it < 12; it++) begin
      irqEn = (it != 2);
      normalFrame(1 + int'($urandom % 260), 9);
    end
    irqEn = 1'b1;

    // R8 ring fully owned
    for (int k = 0; k < NDESC; k++) begin
      len = 1 + int'($urandom % 100);
      fillFrame(len);
      sendFrame(len, 9);
      checkFrame(len);
      swIdx = (swIdx + 1) % NDESC;
    end
    w0 = memWrites;
    fillFrame(50);
    sendFrame(50, 9);
    chk(statusBits[2] == 1'b1, "R8", "no buffer bit", statusBits[2], 1);
    chk(memWrites == w0, "R8", "writes during dropped frame", memWrites - w0, 0);
    clrStat(3'b100);
    chk(statusBits == 3'b010, "R6", "only written bit cleared", statusBits, 3'b010);
    clrStat(3'b111);

    // R9 owned descriptor reached mid-frame; R8 pointer did not move
    freeDescs(1);
    fillFrame(200);
    sendFrame(200, 9);
    begin
      logic [31:0] sw = rdWord(descAt(0) + 4);
      chk(rdWord(descAt(0))[0] == 1'b1, "R8", "frame lands at unmoved pointer", rdWord(descAt(0)), 1);
      chk(sw[15:0] == 16'h4000, "R9", "first buffer status", sw[15:0], 16'h4000);
      chk(statusBits == 3'b100, "R9", "no buffer set, no frame received", statusBits, 3'b100);
    end
    freeDescs(NDESC);
    swIdx = (swIdx + 1) % NDESC;
    clrStat(3'b111);
    normalFrame(60, 9);

    // R10 overflow from a back-to-back burst
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); inValid = 1; inByte = 8'(i); inSof = (i == 0);
    end
    @(negedge clk); inValid = 0; inSof = 0;
    repeat (20) @(negedge clk);
    inValid = 1; inEof = 1; inByte = 8'hEE;
    @(negedge clk); inValid = 0; inEof = 0;
    repeat (40) @(negedge clk);
    begin
      logic [31:0] sw = rdWord(descAt(0) + 4);
      chk(statusBits[0] == 1'b1, "R10", "overflow bit", statusBits[0], 1);
      chk(sw[11:0] < 12'd10 && sw[11:0] > 12'd0 && sw[15], "R10", "stored length below sent", sw[11:0], 10);
    end
    clrStat(3'b001);
    chk(statusBits == 3'b010, "R6", "overflow cleared alone", statusBits, 3'b010);
    clrStat(3'b111);
    freeDescs(1);
    swIdx = (swIdx + 1) % NDESC;
    normalFrame(1 + int'($urandom % 260), 9);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    fork
      runTests();
      begin
        repeat (190000) @(posedge clk);
        timedOut = 1;
      end
    join_any
    if (timedOut) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual timeout expected completion");
    end
    checks += r12Checks;
    fails += r12Fails;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule